// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This controller moves one switchable power domain between full operation and a powered-off state. When the domain asks to go idle, the sequencer first stops the domain clock. If the request lasts for a programmable number of cycles, the break-even interval, it continues into a fixed shutdown order. It clamps the domain outputs, pulses a save strobe so that retention flops capture their state, and then opens all four power-switch banks together. If the idle request ends or a wake request comes before the interval runs out, the domain goes back to running. It stays powered throughout.

A wake request from the off state runs the steps in reverse. The switch banks close one at a time, with a programmable gap between them, so that the in-rush current spreads out. Once every bank is closed, the sequencer waits for a power-good indication from the rail. It then pulses a restore strobe, drops the clamp, and turns the clock back on. If power-good does not arrive within a programmable number of cycles, an error flag is raised and the domain is kept isolated. A wake request that arrives partway through shutdown is remembered and served only after the off state is reached. A 3-bit status code reports the current step.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset the status is ACTIVE (code 0), clk_en_o is 1, iso_en_o is 0, all four bank_en_o bits are 1, save_o, restore_o and pgood_err_o are 0.
- R2: In ACTIVE, idle_req_i high with wake_req_i low moves the block to CLK_GATED (code 1) on the next cycle. In that state clk_en_o is 0 while iso_en_o stays 0 and the banks stay on. One cycle after idle_req_i falls or wake_req_i rises, the block is back in ACTIVE.
- R3: Shutdown begins only after the break-even interval. With idle_req_i held and no wake, the status reads CLK_GATED for exactly idle_thresh_i+1 cycles and then becomes ISOLATING (code 2).
- R4: Shutdown order. ISOLATING lasts one cycle with iso_en_o=1 and clk_en_o=0. SAVING (code 3) follows for two cycles, with save_o=1 in the first cycle only. Then OFF (code 4) is entered, and all bank_en_o bits are 0 from its first cycle.
- R5: dom_out_o is all zeros whenever iso_en_o is 1 and equals dom_out_i whenever iso_en_o is 0.
- R6: A wake request in OFF moves the block to POWERING (code 5) on the next cycle, with only bank_en_o[0] set. Each next bank (bit i+1 after bit i) turns on bank_gap_i+1 cycles after the previous one. During POWERING no enabled bank is turned off.
- R7: With all four banks on, a high pwr_good_i moves the block to RESTORING (code 6) on the next cycle. RESTORING lasts two cycles with restore_o=1 in the first only. It is followed by one cycle of RELEASING (code 7) with iso_en_o=0 and clk_en_o=0, then ACTIVE with clk_en_o=1.
- R8: If pwr_good_i stays low while all banks are on, pgood_err_o is 0 through the cycle where pgood_limit_i cycles have passed and is 1 from the next cycle on. It stays 1 until reset. The block then remains in POWERING with iso_en_o=1, even if power-good arrives later.
- R9: A wake request seen during ISOLATING or SAVING does not shorten shutdown. The block completes SAVING, spends one cycle in OFF, and then enters POWERING with no further request. Without any request, OFF is held.
- R10: save_o and restore_o are never 1 together. Each is 1 only while iso_en_o is 1 and clk_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| idle_req_i | input | 1 | Domain reports it is idle |
| wake_req_i | input | 1 | Request to bring the domain back up |
| pwr_good_i | input | 1 | Virtual rail has settled |
| idle_thresh_i | input | 16 | Break-even idle interval in cycles |
| bank_gap_i | input | 16 | Extra cycles between successive bank enables |
| pgood_limit_i | input | 16 | Cycles allowed for power-good after the last bank |
| dom_out_i | input | 8 | Raw outputs of the switchable domain |
| dom_out_o | output | 8 | Domain outputs as seen by the always-on side |
| clk_en_o | output | 1 | Domain clock enable |
| iso_en_o | output | 1 | Isolation clamp enable |
| save_o | output | 1 | Retention save strobe |
| restore_o | output | 1 | Retention restore strobe |
| bank_en_o | output | 4 | Power-switch bank enables, bit 0 first on wake |
| status_o | output | 3 | Current step code |
| pgood_err_o | output | 1 | Power-good timeout flag |

## Verification
The hardest case to reach is a wake request that arrives in the middle of shutdown, because it only has an effect if it lands in the one-cycle ISOLATING window or the two-cycle SAVING window. The bench sets the break-even interval to zero, so the sequence reaches ISOLATING two cycles after idle is raised. It pulses wake exactly there and checks that saving and one OFF cycle still happen before POWERING starts on its own. The power-good timeout is reached from the same run: a zero bank gap and a rail that never reports good, with the error flag sampled on both sides of the limit.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE    = 3'd0,
    ST_CLK_GATED = 3'd1,
    ST_ISOLATING = 3'd2,
    ST_SAVING    = 3'd3,
    ST_OFF       = 3'd4,
    ST_POWERING  = 3'd5,
    ST_RESTORING = 3'd6,
    ST_RELEASING = 3'd7
  } pgs_state_e;
endpackage

// File: rtl/pgs_cycle_timer.sv
// Counts cycles while run_i is high, clears otherwise; saturates at all ones.
module pgs_cycle_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)               cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/pgs_bank_stagger.sv
// Power-switch bank enables: all cleared at once, turned on one by one.
module pgs_bank_stagger #(
  parameter int NB = 4,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cut_i,
  input  logic          start_i,
  input  logic          run_i,
  input  logic [CW-1:0] gap_i,
  output logic [NB-1:0] bank_o,
  output logic          all_on_o
);
  logic [NB-1:0] bank_q, bank_d;
  logic [CW-1:0] gap_q, gap_d;
  logic          step_en;

  assign all_on_o = &bank_q;
  assign step_en  = run_i && !all_on_o;

  always_comb begin
    bank_d = bank_q;
    gap_d  = gap_q;
    if (cut_i) begin
      bank_d = '0;
      gap_d  = '0;
    end else if (start_i) begin
      bank_d = {{(NB-1){1'b0}}, 1'b1};
      gap_d  = '0;
    end else if (step_en) begin
      if (gap_q >= gap_i) begin
        bank_d = {bank_q[NB-2:0], 1'b1};
        gap_d  = '0;
      end else begin
        gap_d  = gap_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '1;
      gap_q  <= '0;
    end else begin
      bank_q <= bank_d;
      gap_q  <= gap_d;
    end
  end

  assign bank_o = bank_q;
endmodule

// File: rtl/pgs_iso_clamp.sv
// Forces every domain output bit to 0 while isolation is on.
module pgs_iso_clamp #(
  parameter int DW = 8
) (
  input  logic          iso_i,
  input  logic [DW-1:0] raw_i,
  output logic [DW-1:0] safe_o
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign safe_o[b] = raw_i[b] & ~iso_i;
  end
endmodule

// File: rtl/pgs_seq_fsm.sv
module pgs_seq_fsm
  import pgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_req_i,
  input  logic       wake_req_i,
  input  logic       pwr_good_i,
  input  logic       idle_hit_i,
  input  logic       all_on_i,
  input  logic       pg_late_i,
  output pgs_state_e state_o,
  output logic       idle_run_o,
  output logic       pg_run_o,
  output logic       cut_o,
  output logic       start_o,
  output logic       save_o,
  output logic       restore_o,
  output logic       clk_en_o,
  output logic       iso_en_o,
  output logic       err_o
);
  pgs_state_e st_q, st_d;
  logic       ph_q, ph_d;
  logic       pend_q, pend_d;
  logic       err_q, err_d;

  always_comb begin
    st_d      = st_q;
    ph_d      = 1'b0;
    cut_o     = 1'b0;
    start_o   = 1'b0;
    save_o    = 1'b0;
    restore_o = 1'b0;
    unique case (st_q)
      ST_ACTIVE:    if (idle_req_i && !wake_req_i) st_d = ST_CLK_GATED;
      ST_CLK_GATED: begin
        if (wake_req_i || !idle_req_i) st_d = ST_ACTIVE;
        else if (idle_hit_i)           st_d = ST_ISOLATING;
      end
      ST_ISOLATING: st_d = ST_SAVING;
      ST_SAVING: begin
        if (!ph_q) begin
          save_o = 1'b1;
          ph_d   = 1'b1;
        end else begin
          cut_o  = 1'b1;
          st_d   = ST_OFF;
        end
      end
      ST_OFF: begin
        if (wake_req_i || pend_q) begin
          start_o = 1'b1;
          st_d    = ST_POWERING;
        end
      end
      ST_POWERING:  if (all_on_i && pwr_good_i && !err_q) st_d = ST_RESTORING;
      ST_RESTORING: begin
        if (!ph_q) begin
          restore_o = 1'b1;
          ph_d      = 1'b1;
        end else begin
          st_d      = ST_RELEASING;
        end
      end
      ST_RELEASING: st_d = ST_ACTIVE;
      default:      st_d = ST_ACTIVE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (start_o) pend_d = 1'b0;
    else if (wake_req_i && (st_q == ST_ISOLATING || st_q == ST_SAVING)) pend_d = 1'b1;
    err_d = err_q | pg_late_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ACTIVE;
      ph_q   <= 1'b0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  assign state_o    = st_q;
  assign idle_run_o = (st_q == ST_CLK_GATED);
  assign pg_run_o   = (st_q == ST_POWERING) && all_on_i && !pwr_good_i;
  assign clk_en_o   = (st_q == ST_ACTIVE);
  assign iso_en_o   = (st_q == ST_ISOLATING) || (st_q == ST_SAVING) || (st_q == ST_OFF) ||
                      (st_q == ST_POWERING)  || (st_q == ST_RESTORING);
  assign err_o      = err_q;

  // R9: a held wake never lets OFF be skipped
  a_r9_off_before_power: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POWERING && $past(st_q) != ST_POWERING) |-> $past(st_q) == ST_OFF);
endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pgs_pkg::*;
#(
  parameter int CW = 16,
  parameter int NB = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_req_i,
  input  logic          wake_req_i,
  input  logic          pwr_good_i,
  input  logic [CW-1:0] idle_thresh_i,
  input  logic [CW-1:0] bank_gap_i,
  input  logic [CW-1:0] pgood_limit_i,
  input  logic [DW-1:0] dom_out_i,
  output logic [DW-1:0] dom_out_o,
  output logic          clk_en_o,
  output logic          iso_en_o,
  output logic          save_o,
  output logic          restore_o,
  output logic [NB-1:0] bank_en_o,
  output logic [2:0]    status_o,
  output logic          pgood_err_o
);
  pgs_state_e st;
  logic idle_run, idle_hit, pg_run, pg_late, all_on, cut, start;

  pgs_cycle_timer #(.CW(CW)) u_idle_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(idle_run), .limit_i(idle_thresh_i), .hit_o(idle_hit)
  );

  pgs_cycle_timer #(.CW(CW)) u_pg_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(pg_run), .limit_i(pgood_limit_i), .hit_o(pg_late)
  );

  pgs_bank_stagger #(.NB(NB), .CW(CW)) u_banks (
    .clk(clk), .rst_n(rst_n), .cut_i(cut), .start_i(start),
    .run_i(st == ST_POWERING), .gap_i(bank_gap_i), .bank_o(bank_en_o), .all_on_o(all_on)
  );

  pgs_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .idle_req_i(idle_req_i), .wake_req_i(wake_req_i),
    .pwr_good_i(pwr_good_i), .idle_hit_i(idle_hit), .all_on_i(all_on), .pg_late_i(pg_late),
    .state_o(st), .idle_run_o(idle_run), .pg_run_o(pg_run), .cut_o(cut), .start_o(start),
    .save_o(save_o), .restore_o(restore_o), .clk_en_o(clk_en_o), .iso_en_o(iso_en_o),
    .err_o(pgood_err_o)
  );

  pgs_iso_clamp #(.DW(DW)) u_clamp (
    .iso_i(iso_en_o), .raw_i(dom_out_i), .safe_o(dom_out_o)
  );

  assign status_o = st;

  // R4: banks may be off only behind isolation
  a_r4_cut_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en_o != '1) |-> iso_en_o);
  // R6: no enabled bank drops while powering up
  a_r6_banks_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_POWERING && $past(st) == ST_POWERING) |->
      ((bank_en_o & $past(bank_en_o)) == $past(bank_en_o)));
  // R7: restore only with every bank on
  a_r7_restore_full: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> (bank_en_o == '1));
  // R8: error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_err_o |=> pgood_err_o);
  // R10: strobes are exclusive and isolated
  a_r10_strobe_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (save_o || restore_o) |-> (iso_en_o && !clk_en_o && !(save_o && restore_o)));
  // R2: clock never runs while clamped
  a_r2_clk_vs_iso: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o |-> !iso_en_o);
endmodule

// File: tb/pwr_gate_seq_test.sv
module pwr_gate_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        idle_req, wake_req, pgood;
  logic [15:0] thresh, gap, limit;
  logic [7:0]  din, dout;
  logic        clk_en, iso, save, restore, err;
  logic [3:0]  banks;
  logic [2:0]  status;
  int          checks = 0;
  int          failures = 0;

  always #5 clk = ~clk;

  pwr_gate_seq uut (
    .clk(clk), .rst_n(rst_n), .idle_req_i(idle_req), .wake_req_i(wake_req),
    .pwr_good_i(pgood), .idle_thresh_i(thresh), .bank_gap_i(gap), .pgood_limit_i(limit),
    .dom_out_i(din), .dom_out_o(dout), .clk_en_o(clk_en), .iso_en_o(iso), .save_o(save),
    .restore_o(restore), .bank_en_o(banks), .status_o(status), .pgood_err_o(err)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle_req = 0; wake_req = 0; pgood = 0;
    thresh = 16'd10; gap = 16'd2; limit = 16'd5; din = 8'h3C;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 status", status, 0);
    check("R1 clk_en", clk_en, 1);
    check("R1 iso", iso, 0);
    check("R1 banks", banks, 15);
    check("R1 strobes", {save, restore}, 0);
    check("R1 err", err, 0);
    check("R5 pass-through", dout, 8'h3C);
  endtask

  task automatic t_short_idle();
    thresh = 16'd10;
    idle_req = 1; step();
    check("R2 gated status", status, 1);
    check("R2 gated clk_en", clk_en, 0);
    check("R2 gated iso", iso, 0);
    check("R2 gated banks", banks, 15);
    repeat (3) step();
    check("R3 short idle stays gated", status, 1);
    idle_req = 0; step();
    check("R2 back active", status, 0);
    check("R2 clk_en back", clk_en, 1);
  endtask

  task automatic t_wake_abort();
    idle_req = 1; step();
    check("R2 gated again", status, 1);
    wake_req = 1; step();
    check("R2 wake aborts gating", status, 0);
    wake_req = 0; idle_req = 0; step();
    check("R2 stays active", status, 0);
  endtask

  task automatic t_shutdown(input int t);
    int n;
    thresh = 16'(t); din = 8'hA5; n = 0;
    idle_req = 1; step();
    while (status == 3'd1 && n < 100) begin
      n++; step();
    end
    check("R3 gated cycles", n, t + 1);
    check("R4 isolating status", status, 2);
    check("R4 isolating iso", iso, 1);
    check("R4 isolating clk", clk_en, 0);
    check("R4 no early save", save, 0);
    check("R5 clamp", dout, 0);
    step();
    check("R4 saving status", status, 3);
    check("R4 save pulse", save, 1);
    check("R4 banks held", banks, 15);
    step();
    check("R4 settle status", status, 3);
    check("R4 save single", save, 0);
    step();
    check("R4 off status", status, 4);
    check("R4 banks cut", banks, 0);
    check("R5 clamp off", dout, 0);
    idle_req = 0; step();
    check("R9 off held", status, 4);
  endtask

  task automatic t_wake(input int g);
    gap = 16'(g); pgood = 1;
    wake_req = 1; step(); wake_req = 0;
    for (int i = 0; i < 3 * (g + 1) + 1; i++) begin
      int c;
      c = i / (g + 1) + 1;
      if (c > 4) c = 4;
      check("R6 stagger banks", banks, (1 << c) - 1);
      check("R6 powering status", status, 5);
      step();
    end
    check("R7 restoring", status, 6);
    check("R7 restore pulse", restore, 1);
    check("R7 iso during restore", iso, 1);
    step();
    check("R7 restore single", restore, 0);
    check("R7 settle status", status, 6);
    step();
    check("R7 releasing", status, 7);
    check("R7 iso released", iso, 0);
    check("R7 clk still gated", clk_en, 0);
    check("R5 released pass", dout, 8'hA5);
    step();
    check("R7 active", status, 0);
    check("R7 clk on", clk_en, 1);
    pgood = 0;
  endtask

  task automatic t_wake_held_and_timeout();
    thresh = 0; gap = 0; limit = 16'd5; pgood = 0;
    idle_req = 1; step();
    check("R3 zero thresh gated", status, 1);
    step();
    check("R9 isolating", status, 2);
    wake_req = 1; idle_req = 0; step(); wake_req = 0;
    check("R9 save not skipped", status, 3);
    check("R9 save pulse", save, 1);
    step();
    check("R9 settle", status, 3);
    step();
    check("R9 off visited", status, 4);
    step();
    check("R9 auto powering", status, 5);
    check("R9 first bank", banks, 1);
    repeat (3) step();
    check("R6 zero gap full", banks, 15);
    repeat (5) step();
    check("R8 no early err", err, 0);
    step();
    check("R8 err raised", err, 1);
    check("R8 parked", status, 5);
    check("R8 iso held", iso, 1);
    pgood = 1; step();
    check("R8 late pgood ignored", status, 5);
    check("R8 err sticky", err, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_short_idle();
    t_wake_abort();
    t_shutdown(3);
    t_wake(2);
    t_wake_held_and_timeout();
    t_reset();
    t_shutdown(0);
    t_wake(0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule